// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Almost-Full / Almost-Empty Thresholds

This block is a first-in first-out buffer that connects a writer and a reader running on unrelated clocks. The data path is 9 bits wide. The depth is a power of two and is set by a parameter. Words pushed on the write clock come out in the same order on the read clock. Four active-low status outputs report the fill state. Full and almost-full are updated on the write clock. Empty and almost-empty are updated on the read clock.

The two partial-flag thresholds are not fixed. The empty threshold `n` and the full threshold `m` are each 16 bits, held as a low byte and a high byte. Software loads them by holding the load control low while strobing the write enable. Each strobe puts `wdata[7:0]` into the next of four byte registers, stepping through a fixed cycle. Holding load low while strobing both read enables returns the same four bytes on `rdata`, in the same cycle. The read side keeps its own step counter for this.

Each side passes its Gray-coded pointer to the other clock domain through a two-stage synchronizer. Each flag is computed in its own domain from the local pointer and the synchronized remote pointer, then registered once.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, that domain's state is cleared. After reset, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. Both offset step counters return to step 0. The offsets return to n=7 and m=7.
- R2: Words accepted on the write side are delivered on `rdata` in arrival order. `rdata` is updated on the read-clock edge that performs the read.
- R3: `empty_n` is low exactly when no unread word is stored. A read attempted while `empty_n` is low is ignored: `rdata` and the stored contents stay unchanged.
- R4: `full_n` is low exactly when DEPTH words are stored. A data write attempted while `full_n` is low is dropped and never appears on the read side.
- R5: `aempty_n` is low when the unread count is n or less. It is high when the count is n+1 or more.
- R6: `afull_n` is low when the unread count is DEPTH−m or more. It is high otherwise.
- R7: While `wr_en_n` is high, a write-clock edge changes nothing, whatever the level of `ld_n`.
- R8: When `ld_n`=0 and `wr_en_n`=0, each write-clock edge stores `wdata[7:0]` into one offset byte and writes nothing to the FIFO. The bytes are taken in this order, after which the order wraps back to step 0:
  - step 0: low byte of n
  - step 1: high byte of n
  - step 2: low byte of m
  - step 3: high byte of m
- R9: When `ld_n`=0 and both `rd_en_n` and `rd_en2_n` are 0, each read-clock edge places the next offset byte on `rdata[7:0]`, with `rdata[8]`=0. It uses the same four-step wrapping order and removes no FIFO word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| wr_en_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low load: selects the offset registers instead of the FIFO |
| wdata | input | 9 | Write data; bits 7:0 carry offset bytes |
| rd_en_n | input | 1 | Active-low read strobe, first of two |
| rd_en2_n | input | 1 | Active-low read strobe, second of two |
| rdata | output | 9 | Read data or offset readback byte |
| full_n | output | 1 | Low when the FIFO is full |
| afull_n | output | 1 | Low when the unread count is at least DEPTH−m |
| empty_n | output | 1 | Low when the FIFO is empty |
| aempty_n | output | 1 | Low when the unread count is at most n |

## Verification
The bench steps the fill level across every threshold edge: n, n+1, DEPTH−m−1, DEPTH−m and DEPTH. A comparison that is off by one would move a partial flag one word early or late, and the bench would see it.

The bench writes into a full FIFO and reads from an empty one. A missing guard would show up in two ways: a spurious extra word in the read sequence, or a wrapped pointer that makes the FIFO look empty while it is full.

The offset sequence is driven past its fourth step, so a load that fails to wrap would overwrite the full threshold instead. The readback is interleaved with stored data, so a readback that also pops a word would skip data.

// File: rtl/pff_pkg.sv
// Package: shared types for the programmable-flag FIFO.
// Assumes: exactly four offset byte registers, selected in a fixed rotation.
package pff_pkg;
    localparam int BYTE_W = 8;

    // Offset-register step order; the numeric order is the load/readback order.
    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } ofs_sel_e;
endpackage

// File: rtl/gray_sync.sv
// Module: two-stage synchronizer for a Gray-coded pointer.
// Assumes: the input changes by at most one bit per source-clock edge.
module gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Purpose: two flops in the destination clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/fifo_wr_side.sv
// Module: write pointer, full flag and almost-full flag (write clock domain).
// Assumes: rgray_s is the read pointer already synchronized to clk;
//          m is quasi-static while flags are being relied on.
module fifo_wr_side #(
    parameter int AW = 4,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [AW:0]   rgray_s,
    input  logic [OW-1:0] m,
    output logic          push,
    output logic [AW:0]   wbin_q,
    output logic [AW:0]   wgray_q,
    output logic          full_n_q,
    output logic          afull_n_q
);
    localparam int DEPTH = 1 << AW;

    logic [AW:0] rbin_s;
    logic [AW:0] wbin_nx;
    logic [AW:0] fill_nx;
    logic [OW:0] fill_plus_m;

    // Purpose: a data write is accepted only while the FIFO is not full.
    assign push    = push_req && full_n_q;
    assign wbin_nx = wbin_q + {{AW{1'b0}}, push};

    // Purpose: convert the synchronized read pointer from Gray to binary.
    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    assign fill_nx     = wbin_nx - rbin_s;
    assign fill_plus_m = {{(OW-AW){1'b0}}, fill_nx} + {1'b0, m};

    // Purpose: advance the pointer and register the full and almost-full flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin_q    <= '0;
            wgray_q   <= '0;
            full_n_q  <= 1'b1;
            afull_n_q <= 1'b1;
        end else begin
            wbin_q    <= wbin_nx;
            wgray_q   <= wbin_nx ^ (wbin_nx >> 1);
            full_n_q  <= !(fill_nx == (AW+1)'(DEPTH));
            afull_n_q <= !(fill_plus_m >= (OW+1)'(DEPTH));
        end
    end

    // R4: a write attempted while full leaves the write pointer unchanged.
    p_full_blocks_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n_q && push_req) |=> $stable(wbin_q));

    // R6: a full FIFO is always almost-full as well.
    p_full_implies_afull_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n_q |-> !afull_n_q);
endmodule

// File: rtl/fifo_rd_side.sv
// Module: read pointer, empty flag and almost-empty flag (read clock domain).
// Assumes: wgray_s is the write pointer already synchronized to clk;
//          n is quasi-static while flags are being relied on.
module fifo_rd_side #(
    parameter int AW = 4,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    input  logic [AW:0]   wgray_s,
    input  logic [OW-1:0] n,
    output logic          pop,
    output logic [AW:0]   rbin_q,
    output logic [AW:0]   rgray_q,
    output logic          empty_n_q,
    output logic          aempty_n_q
);
    logic [AW:0] wbin_s;
    logic [AW:0] rbin_nx;
    logic [AW:0] fill_nx;
    logic [OW:0] fill_ext;

    // Purpose: a read is accepted only while the FIFO is not empty.
    assign pop     = pop_req && empty_n_q;
    assign rbin_nx = rbin_q + {{AW{1'b0}}, pop};

    // Purpose: convert the synchronized write pointer from Gray to binary.
    always_comb begin
        wbin_s[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    assign fill_nx  = wbin_s - rbin_nx;
    assign fill_ext = {{(OW-AW){1'b0}}, fill_nx};

    // Purpose: advance the pointer and register the empty and almost-empty flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin_q     <= '0;
            rgray_q    <= '0;
            empty_n_q  <= 1'b0;
            aempty_n_q <= 1'b0;
        end else begin
            rbin_q     <= rbin_nx;
            rgray_q    <= rbin_nx ^ (rbin_nx >> 1);
            empty_n_q  <= (fill_nx != '0);
            aempty_n_q <= (fill_ext > {1'b0, n});
        end
    end

    // R3: a read attempted while empty leaves the read pointer unchanged.
    p_empty_blocks_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n_q && pop_req) |=> $stable(rbin_q));

    // R5: an empty FIFO is always almost-empty as well.
    p_empty_implies_aempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n_q |-> !aempty_n_q);
endmodule

// File: rtl/offset_regs.sv
// Module: four offset byte registers with a rotating load step (write clock)
//         and an independent rotating readback step (read clock).
// Assumes: offsets are loaded while the FIFO flags are not in use; the
//          byte values cross to the read domain as quasi-static data.
module offset_regs
    import pff_pkg::*;
#(
    parameter int OW        = 16,
    parameter int DEF_EMPTY = 7,
    parameter int DEF_FULL  = 7
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              load_rd,
    output logic [BYTE_W-1:0] rb_byte,
    output logic [OW-1:0]     n,
    output logic [OW-1:0]     m
);
    localparam int NREG = 4;
    localparam logic [OW-1:0] DEF_N = OW'(DEF_EMPTY);
    localparam logic [OW-1:0] DEF_M = OW'(DEF_FULL);

    logic [BYTE_W-1:0] regs_q [NREG];
    ofs_sel_e          wsel_q;
    ofs_sel_e          rsel_q;

    // Purpose: reset defaults, then store one byte per load strobe and step on.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            regs_q[SEL_EMPTY_LO] <= DEF_N[BYTE_W-1:0];
            regs_q[SEL_EMPTY_HI] <= DEF_N[2*BYTE_W-1:BYTE_W];
            regs_q[SEL_FULL_LO]  <= DEF_M[BYTE_W-1:0];
            regs_q[SEL_FULL_HI]  <= DEF_M[2*BYTE_W-1:BYTE_W];
            wsel_q               <= SEL_EMPTY_LO;
        end else if (load_wr) begin
            regs_q[wsel_q] <= wbyte;
            wsel_q         <= ofs_sel_e'(wsel_q + 2'd1);
        end
    end

    // Purpose: readback step counter in the read domain.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rsel_q <= SEL_EMPTY_LO;
        end else if (load_rd) begin
            rsel_q <= ofs_sel_e'(rsel_q + 2'd1);
        end
    end

    assign rb_byte = regs_q[rsel_q];
    assign n = {regs_q[SEL_EMPTY_HI], regs_q[SEL_EMPTY_LO]};
    assign m = {regs_q[SEL_FULL_HI], regs_q[SEL_FULL_LO]};

    // R8: after the last step, the load step returns to step 0.
    p_load_wraps_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        (load_wr && wsel_q == SEL_FULL_HI) |=> (wsel_q == SEL_EMPTY_LO));

    // R9: after the last step, the readback step returns to step 0.
    p_readback_wraps_r9: assert property (@(posedge rclk) disable iff (!rst_n)
        (load_rd && rsel_q == SEL_FULL_HI) |=> (rsel_q == SEL_EMPTY_LO));
endmodule

// File: rtl/prog_flag_fifo.sv
// Module: top of the dual-clock FIFO with run-time programmable partial flags.
// Assumes: DATA_W >= 8, OFS_W = 16 (two bytes), OFS_W > ADDR_W;
//          rst_n is held low for several edges of both clocks.
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int ADDR_W    = 4,
    parameter int OFS_W     = 16,
    parameter int DEF_EMPTY = 7,
    parameter int DEF_FULL  = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en_n,
    input  logic              rd_en2_n,
    output logic [DATA_W-1:0] rdata,
    output logic              full_n,
    output logic              afull_n,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic              push_req, push, load_wr;
    logic              pop_req, pop, load_rd;
    logic [PW-1:0]     wbin, wgray, wgray_s;
    logic [PW-1:0]     rbin, rgray, rgray_s;
    logic [OFS_W-1:0]  ofs_n, ofs_m;
    logic [BYTE_W-1:0] rb_byte;
    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: decode the load control and strobes into FIFO and offset operations.
    assign push_req = !wr_en_n && ld_n;
    assign load_wr  = !wr_en_n && !ld_n;
    assign pop_req  = !rd_en_n && !rd_en2_n && ld_n;
    assign load_rd  = !rd_en_n && !rd_en2_n && !ld_n;

    fifo_wr_side #(.AW(ADDR_W), .OW(OFS_W)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .push_req(push_req), .rgray_s(rgray_s),
        .m(ofs_m), .push(push), .wbin_q(wbin), .wgray_q(wgray),
        .full_n_q(full_n), .afull_n_q(afull_n)
    );

    fifo_rd_side #(.AW(ADDR_W), .OW(OFS_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .pop_req(pop_req), .wgray_s(wgray_s),
        .n(ofs_n), .pop(pop), .rbin_q(rbin), .rgray_q(rgray),
        .empty_n_q(empty_n), .aempty_n_q(aempty_n)
    );

    gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    offset_regs #(.OW(OFS_W), .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)) u_ofs (
        .wclk(wr_clk), .rclk(rd_clk), .rst_n(rst_n),
        .load_wr(load_wr), .wbyte(wdata[BYTE_W-1:0]),
        .load_rd(load_rd), .rb_byte(rb_byte), .n(ofs_n), .m(ofs_m)
    );

    // Purpose: storage array write port.
    always_ff @(posedge wr_clk) begin
        if (push) begin
            mem[wbin[ADDR_W-1:0]] <= wdata;
        end
    end

    // Purpose: registered read port, shared by FIFO data and offset readback.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (pop) begin
            rdata <= mem[rbin[ADDR_W-1:0]];
        end else if (load_rd) begin
            rdata <= {{(DATA_W-BYTE_W){1'b0}}, rb_byte};
        end
    end

    // R9: a readback cycle never moves the read pointer.
    p_readback_no_pop_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        load_rd |=> $stable(rbin));
endmodule

// File: tb/sim_prog_flag_fifo.sv
`timescale 1ns/1ps
module sim_prog_flag_fifo;
    logic       wr_clk, rd_clk, rst_n;
    logic       wr_en_n, ld_n, rd_en_n, rd_en2_n;
    logic [8:0] wdata, rdata;
    logic       full_n, afull_n, empty_n, aempty_n;

    int checks = 0;
    int fails  = 0;
    logic [8:0] wr_val = 9'd1;
    logic [8:0] rd_val = 9'd1;
    logic [8:0] last_rd = 9'd0;

    prog_flag_fifo u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .ld_n(ld_n), .wdata(wdata), .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n),
        .rdata(rdata), .full_n(full_n), .afull_n(afull_n),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    initial begin wr_clk = 0; forever #2.5 wr_clk = ~wr_clk; end
    initial begin rd_clk = 0; #1.25; forever #2.5 rd_clk = ~rd_clk; end

    // Vector: {op[1:0], count[5:0], empty_n, aempty_n, afull_n, full_n}
    // op 0 = write count words, 1 = read count words, 2 = write into full, 3 = read from empty
    // Defaults n=7, m=7, DEPTH=16: almost-full from 9 words.
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 6'd1,  4'b1011},   // 1 word
        {2'd0, 6'd6,  4'b1011},   // 7 = n
        {2'd0, 6'd1,  4'b1111},   // 8 = n+1
        {2'd0, 6'd1,  4'b1101},   // 9 = DEPTH-m
        {2'd0, 6'd6,  4'b1101},   // 15
        {2'd0, 6'd1,  4'b1100},   // 16 full
        {2'd2, 6'd1,  4'b1100},   // write while full
        {2'd1, 6'd8,  4'b1111},   // 8
        {2'd1, 6'd1,  4'b1011},   // 7
        {2'd1, 6'd7,  4'b0011},   // 0 empty
        {2'd3, 6'd1,  4'b0011},   // read while empty
        {2'd0, 6'd3,  4'b1011},   // 3
        {2'd1, 6'd3,  4'b0011}    // 0
    };

    task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input logic [3:0] exp);
        chk("R3", "empty_n",  {8'd0, empty_n},  {8'd0, exp[3]});
        chk("R5", "aempty_n", {8'd0, aempty_n}, {8'd0, exp[2]});
        chk("R6", "afull_n",  {8'd0, afull_n},  {8'd0, exp[1]});
        chk("R4", "full_n",   {8'd0, full_n},   {8'd0, exp[0]});
    endtask

    task automatic wr_op(input logic ld, input logic [8:0] d);
        @(negedge wr_clk); ld_n = ld; wr_en_n = 1'b0; wdata = d;
        @(negedge wr_clk); wr_en_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic rd_op(input logic ld, output logic [8:0] d);
        @(negedge rd_clk); ld_n = ld; rd_en_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge rd_clk); rd_en_n = 1'b1; rd_en2_n = 1'b1; ld_n = 1'b1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (8) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    task automatic do_reset();
        @(negedge wr_clk); rst_n = 1'b0;
        repeat (6) @(negedge wr_clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic push_n(input int cnt);
        for (int k = 0; k < cnt; k++) begin wr_op(1'b1, wr_val); wr_val++; end
    endtask

    task automatic pop_n(input int cnt);
        logic [8:0] d;
        for (int k = 0; k < cnt; k++) begin
            rd_op(1'b1, d);
            chk("R2", "read data order", d, rd_val);
            rd_val++; last_rd = d;
        end
    endtask

    task automatic readback(input logic [7:0] b0, b1, b2, b3, input string req);
        logic [8:0] d;
        rd_op(1'b0, d); chk(req, "readback step0", d, {1'b0, b0});
        rd_op(1'b0, d); chk(req, "readback step1", d, {1'b0, b1});
        rd_op(1'b0, d); chk(req, "readback step2", d, {1'b0, b2});
        rd_op(1'b0, d); chk(req, "readback step3", d, {1'b0, b3});
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [8:0] d;
        rst_n = 1'b0; wr_en_n = 1'b1; ld_n = 1'b1; rd_en_n = 1'b1; rd_en2_n = 1'b1; wdata = '0;
        do_reset();
        // R1: reset flag values
        chk("R1", "reset empty_n",  {8'd0, empty_n},  9'd0);
        chk("R1", "reset aempty_n", {8'd0, aempty_n}, 9'd0);
        chk("R1", "reset afull_n",  {8'd0, afull_n},  9'd1);
        chk("R1", "reset full_n",   {8'd0, full_n},   9'd1);

        // Vector table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][11:10])
                2'd0: push_n(int'(VEC[i][9:4]));
                2'd1: pop_n(int'(VEC[i][9:4]));
                2'd2: wr_op(1'b1, 9'h1FF);            // R4: must be dropped
                default: begin
                    rd_op(1'b1, d);
                    chk("R3", "read while empty keeps rdata", d, last_rd);
                end
            endcase
            settle();
            chk_flags(VEC[i][3:0]);
        end

        // R7: wr_en_n high does nothing with ld_n low or high
        @(negedge wr_clk); wr_en_n = 1'b1; ld_n = 1'b0; wdata = 9'h055;
        repeat (4) @(negedge wr_clk);
        ld_n = 1'b1; wdata = 9'h0AA;
        repeat (4) @(negedge wr_clk);
        settle();
        chk("R7", "no write with wr_en_n high", {8'd0, empty_n}, 9'd0);
        readback(8'd7, 8'd0, 8'd7, 8'd0, "R7");   // also R1 defaults via R9

        // R8: load sequence with wrap; fifth strobe rewrites empty low byte
        wr_op(1'b0, 9'h002); wr_op(1'b0, 9'h000);
        wr_op(1'b0, 9'h003); wr_op(1'b0, 9'h000);
        wr_op(1'b0, 9'h104);
        settle();
        chk("R8", "load does not enqueue", {8'd0, empty_n}, 9'd0);
        readback(8'd4, 8'd0, 8'd3, 8'd0, "R8");

        // Thresholds now n=4, m=3: almost-full from 13 words
        push_n(4); settle();
        chk("R5", "aempty_n at n=4", {8'd0, aempty_n}, 9'd0);
        push_n(1); settle();
        chk("R5", "aempty_n at n+1", {8'd0, aempty_n}, 9'd1);
        push_n(7); settle();
        chk("R6", "afull_n at 12", {8'd0, afull_n}, 9'd1);
        push_n(1); settle();
        chk("R6", "afull_n at 13", {8'd0, afull_n}, 9'd0);
        // R9: readback with data stored removes nothing
        readback(8'd4, 8'd0, 8'd3, 8'd0, "R9");
        settle();
        chk("R9", "readback keeps count", {8'd0, afull_n}, 9'd0);
        pop_n(1); settle();
        chk("R6", "afull_n back at 12", {8'd0, afull_n}, 9'd1);
        pop_n(12); settle();
        chk("R3", "empty after drain", {8'd0, empty_n}, 9'd0);

        // R1: reset mid-run clears contents and offsets
        push_n(3); settle();
        do_reset();
        chk("R1", "reset empty_n again",  {8'd0, empty_n},  9'd0);
        chk("R1", "reset aempty_n again", {8'd0, aempty_n}, 9'd0);
        readback(8'd7, 8'd0, 8'd7, 8'd0, "R1");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule